// File: doc/BRIEF.md
# DMA Channel Enable and Global Run Gate

This block sits next to the channels of a multi-channel DMA controller and decides, every clock, which channels may transfer. It holds two kinds of state. The first is one enable bit per channel. The second is a shared 16-bit run-control word, which carries a master run bit, two sticky fault flags (non-maskable interrupt and address error) and a two-bit priority field. The priority field is stored here and passed on to other logic; this block does not interpret it.

A channel is granted a registered permit only when all of the following hold:
- its own enable bit is set;
- the master run bit is set;
- its transfer-end input is low;
- both fault flags are clear.

What else a channel needs depends on its request mode. An auto-request channel needs nothing further. A channel in external or peripheral request mode must also see its request line high.

Software reaches the state through a small register bus. The run-control word sits at address 0, and the enable bit of channel `c` sits at bit 0 of address `c+1`. The fault flags are set by hardware. Software can only clear a fault flag, by writing 0 to it. A synchronous standby input clears all state, exactly as reset does.

Top module: `dmagate_ctrl`

## Requirements
- R1: After reset, address 0 and every channel address read 0x0000, and every permit bit is 0.
- R2: A cycle with standby high clears all channel enables, the whole run-control word (flags included) and every permit, so that they read as they do after reset.
- R3: A channel in auto-request mode (mode bit 0) has permit 1 from the second clock edge after its enable bit and the master run bit (address 0, bit 0) are both 1, provided its transfer-end input is 0 and both fault flags are 0.
- R4: A channel in external-request mode (mode bit 1) has permit 1 in the cycle after a clock edge at which its request line was 1 with all gating conditions met, and permit 0 after an edge at which its request line was 0.
- R5: A high transfer-end input on a channel forces that channel's permit to 0 after the next edge and leaves the other channels unaffected.
- R6: A high NMI input at a clock edge sets the NMI flag (address 0, bit 1) at that edge, and every permit is 0 after the following edge.
- R7: A high address-error input at a clock edge sets the address-error flag (address 0, bit 2) at that edge, and every permit is 0 after the following edge.
- R8: Writing 0 to a fault flag bit clears it. Writing 1 to it leaves it unchanged, and never sets a clear flag.
- R9: When a hardware set of a fault flag and a software write of 0 to that flag happen at the same edge, the flag ends up 1.
- R10: At address 0, bits 9:8 (priority) and bit 0 (master run) read back what was written. Bits 15:10 and 7:3 always read 0, whatever is written.
- R11: Clearing the master run bit makes every permit 0 no later than the second edge after the write.
- R12: Clearing a channel's enable bit makes its permit 0 no later than the second edge after the write.
- R13: A channel address holds only bit 0; its other bits read 0. Addresses above the last channel read 0, and writes to them change no register and no permit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| standby | input | 1 | Synchronous clear of all state, same effect as reset |
| bus_addr | input | ADDR_W | Register address: 0 is run control, c+1 is channel c |
| bus_wr | input | 1 | Write strobe, takes effect at the clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| mode_ext | input | NUM_CH | Per channel: 0 auto-request, 1 external/peripheral request |
| req | input | NUM_CH | Per-channel transfer request line |
| xfer_end | input | NUM_CH | Per-channel transfer-end status |
| nmi_in | input | 1 | Non-maskable interrupt event, sets the NMI flag |
| addr_err | input | 1 | Address-error event, sets the address-error flag |
| permit | output | NUM_CH | Registered per-channel transfer permit |

## Verification
Two cases are hard to reach from the ports. The first is a hardware flag set and a software clear of the same flag landing on the same edge. The bench reaches it by driving the NMI input and a write of 0 to address 0 in the same cycle, then reading the flag back. The second is the one-cycle lag between a flag being visible and the permits falling. The bench samples both the flag and the permit in the cycle right after the event, and again one cycle later. Every combination of enable, master run, transfer-end, request, mode and fault state is swept on each channel, with the expected permit worked out arithmetically.

// File: rtl/dmagate_pkg.sv
package dmagate_pkg;

    localparam int REG_W    = 16;
    localparam int PRI_LSB  = 8;
    localparam int PRI_W    = 2;
    localparam int AE_BIT   = 2;
    localparam int NMIF_BIT = 1;
    localparam int RUN_BIT  = 0;
    localparam int CH_EN_BIT = 0;

    typedef enum logic {
        REQ_AUTO = 1'b0,
        REQ_EXT  = 1'b1
    } req_mode_e;

    typedef struct packed {
        logic [PRI_W-1:0] pri;
        logic             ae;
        logic             nmif;
        logic             run;
    } runctl_t;

    function automatic logic [REG_W-1:0] runctl_to_word(runctl_t r);
        logic [REG_W-1:0] w;
        w = '0;
        w[PRI_LSB +: PRI_W] = r.pri;
        w[AE_BIT]           = r.ae;
        w[NMIF_BIT]         = r.nmif;
        w[RUN_BIT]          = r.run;
        return w;
    endfunction

    function automatic runctl_t word_to_runctl(logic [REG_W-1:0] w);
        runctl_t r;
        r.pri  = w[PRI_LSB +: PRI_W];
        r.ae   = w[AE_BIT];
        r.nmif = w[NMIF_BIT];
        r.run  = w[RUN_BIT];
        return r;
    endfunction

    // sticky flag: hardware set has priority, software may only clear
    function automatic logic sticky_next(logic cur, logic hw_set,
                                         logic sw_wr, logic sw_bit);
        if (hw_set)
            return 1'b1;
        else if (sw_wr)
            return cur & sw_bit;
        else
            return cur;
    endfunction

endpackage

// File: rtl/dmagate_runctl.sv
module dmagate_runctl
    import dmagate_pkg::*;
(
    input  logic    clk,
    input  logic    clr,
    input  logic    wr_hit,
    input  runctl_t wr_val,
    input  logic    nmi_evt,
    input  logic    aerr_evt,
    output runctl_t state
);

    runctl_t state_q;
    runctl_t state_d;

    always_comb begin
        state_d      = state_q;
        state_d.nmif = sticky_next(state_q.nmif, nmi_evt,  wr_hit, wr_val.nmif);
        state_d.ae   = sticky_next(state_q.ae,   aerr_evt, wr_hit, wr_val.ae);
        if (wr_hit) begin
            state_d.run = wr_val.run;
            state_d.pri = wr_val.pri;
        end
    end

    always_ff @(posedge clk) begin
        if (clr)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign state = state_q;

    // R9: hardware set wins over a same-cycle software clear
    a_r9_set_wins: assert property (@(posedge clk) disable iff (clr)
        nmi_evt |=> state_q.nmif);

    // R8: writing 1 to a clear flag does not set it
    a_r8_one_keeps: assert property (@(posedge clk) disable iff (clr)
        (wr_hit && wr_val.ae && !state_q.ae && !aerr_evt) |=> !state_q.ae);

    // R10: priority field is plain read/write
    a_r10_pri_rw: assert property (@(posedge clk) disable iff (clr)
        wr_hit |=> (state_q.pri == $past(wr_val.pri)));

endmodule

// File: rtl/dmagate_chan.sv
module dmagate_chan
    import dmagate_pkg::*;
(
    input  logic      clk,
    input  logic      clr,
    input  logic      wr_hit,
    input  logic      wr_bit,
    input  req_mode_e mode,
    input  logic      req,
    input  logic      xfer_end,
    input  logic      glob_ok,
    output logic      en,
    output logic      permit
);

    logic en_q;
    logic permit_q;
    logic gate_ok;
    logic want;

    always_ff @(posedge clk) begin
        if (clr)
            en_q <= 1'b0;
        else if (wr_hit)
            en_q <= wr_bit;
    end

    assign gate_ok = en_q & glob_ok & ~xfer_end;
    assign want    = (mode == REQ_AUTO) ? 1'b1 : req;

    always_ff @(posedge clk) begin
        if (clr)
            permit_q <= 1'b0;
        else
            permit_q <= gate_ok & want;
    end

    assign en     = en_q;
    assign permit = permit_q;

    // R12: a cleared enable stops the channel by the next edge
    a_r12_en_stops: assert property (@(posedge clk) disable iff (clr)
        $fell(en_q) |=> !permit_q);

    // R4: external mode without a request yields no permit
    a_r4_ext_needs_req: assert property (@(posedge clk) disable iff (clr)
        (mode == REQ_EXT && !req) |=> !permit_q);

    // R5: transfer end blocks the channel
    a_r5_end_blocks: assert property (@(posedge clk) disable iff (clr)
        xfer_end |=> !permit_q);

endmodule

// File: rtl/dmagate_rdmux.sv
module dmagate_rdmux
    import dmagate_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 4
)(
    input  logic [ADDR_W-1:0] addr,
    input  runctl_t           ctl,
    input  logic [NUM_CH-1:0] en,
    output logic [REG_W-1:0]  rdata
);

    always_comb begin
        rdata = '0;
        if (addr == '0)
            rdata = runctl_to_word(ctl);
        for (int c = 0; c < NUM_CH; c++) begin
            if (addr == ADDR_W'(c + 1))
                rdata[CH_EN_BIT] = en[c];
        end
    end

endmodule

// File: rtl/dmagate_ctrl.sv
module dmagate_ctrl
    import dmagate_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 4
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              standby,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic [NUM_CH-1:0] mode_ext,
    input  logic [NUM_CH-1:0] req,
    input  logic [NUM_CH-1:0] xfer_end,
    input  logic              nmi_in,
    input  logic              addr_err,
    output logic [NUM_CH-1:0] permit
);

    localparam int NUM_REGS = NUM_CH + 1;

    initial begin
        if (NUM_REGS > (1 << ADDR_W))
            $error("ADDR_W too small for NUM_CH");
    end

    logic              clr;
    logic              ctl_wr;
    runctl_t           ctl;
    logic              glob_ok;
    logic [NUM_CH-1:0] en_vec;

    assign clr    = rst | standby;
    assign ctl_wr = bus_wr && (bus_addr == '0);

    dmagate_runctl u_runctl (
        .clk      (clk),
        .clr      (clr),
        .wr_hit   (ctl_wr),
        .wr_val   (word_to_runctl(bus_wdata)),
        .nmi_evt  (nmi_in),
        .aerr_evt (addr_err),
        .state    (ctl)
    );

    assign glob_ok = ctl.run & ~ctl.nmif & ~ctl.ae;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic ch_wr;
        assign ch_wr = bus_wr && (bus_addr == ADDR_W'(c + 1));

        dmagate_chan u_chan (
            .clk      (clk),
            .clr      (clr),
            .wr_hit   (ch_wr),
            .wr_bit   (bus_wdata[CH_EN_BIT]),
            .mode     (req_mode_e'(mode_ext[c])),
            .req      (req[c]),
            .xfer_end (xfer_end[c]),
            .glob_ok  (glob_ok),
            .en       (en_vec[c]),
            .permit   (permit[c])
        );
    end

    dmagate_rdmux #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_rdmux (
        .addr  (bus_addr),
        .ctl   (ctl),
        .en    (en_vec),
        .rdata (bus_rdata)
    );

    // R6: NMI event drops all permits one cycle after the flag sets
    a_r6_nmi_halts: assert property (@(posedge clk) disable iff (rst)
        nmi_in |=> ##1 (permit == '0));

    // R7: address error drops all permits one cycle after the flag sets
    a_r7_aerr_halts: assert property (@(posedge clk) disable iff (rst)
        addr_err |=> ##1 (permit == '0));

    // R11: master run low means no permit on the next edge
    a_r11_run_gates: assert property (@(posedge clk) disable iff (rst)
        !ctl.run |=> (permit == '0));

    // R2: standby clears everything
    a_r2_standby_clears: assert property (@(posedge clk) disable iff (rst)
        standby |=> (permit == '0 && ctl == '0 && en_vec == '0));

endmodule

// File: tb/dmagate_ctrl_bench.sv
module dmagate_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int AW  = 4;

    logic           clk = 1'b0;
    logic           rst;
    logic           standby;
    logic [AW-1:0]  bus_addr;
    logic           bus_wr;
    logic [15:0]    bus_wdata;
    logic [15:0]    bus_rdata;
    logic [NCH-1:0] mode_ext;
    logic [NCH-1:0] req;
    logic [NCH-1:0] xfer_end;
    logic           nmi_in;
    logic           addr_err;
    logic [NCH-1:0] permit;

    int n_vec  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dmagate_ctrl #(.NUM_CH(NCH), .ADDR_W(AW)) u_dmagate_ctrl (
        .clk(clk), .rst(rst), .standby(standby),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .mode_ext(mode_ext), .req(req),
        .xfer_end(xfer_end), .nmi_in(nmi_in), .addr_err(addr_err),
        .permit(permit)
    );

    task automatic chk(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic clear_all();
        mode_ext = '0; req = '0; xfer_end = '0;
        nmi_in = 1'b0; addr_err = 1'b0;
        standby = 1'b1;
        @(negedge clk);
        standby = 1'b0;
    endtask

    initial begin
        cyc(150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] d;
        rst = 1'b1; standby = 1'b0; bus_addr = '0; bus_wr = 1'b0;
        bus_wdata = '0; mode_ext = '0; req = '0; xfer_end = '0;
        nmi_in = 1'b0; addr_err = 1'b0;
        cyc(3);
        rst = 1'b0;
        cyc(1);

        // R1: reset state
        for (int a = 0; a <= NCH; a++) begin
            rd(AW'(a), d);
            chk("R1 read", 32'(d), 32'h0);
        end
        chk("R1 permit", 32'(permit), 32'h0);

        // R3 R4 R5 R6 R7: sweep of every gating combination on every channel
        for (int ch = 0; ch < NCH; ch++) begin
            for (int v = 0; v < 32; v++) begin
                for (int f = 0; f < 3; f++) begin
                    logic en, run, te, rq, md, expb;
                    string tag;
                    en = v[0]; run = v[1]; te = v[2]; rq = v[3]; md = v[4];
                    clear_all();
                    mode_ext = NCH'(md) << ch;
                    req      = NCH'(rq) << ch;
                    xfer_end = NCH'(te) << ch;
                    if (en) wr(AW'(ch + 1), 16'h0001);
                    wr('0, {15'h0, run});
                    if (f == 1) begin nmi_in = 1'b1; cyc(1); nmi_in = 1'b0; end
                    if (f == 2) begin addr_err = 1'b1; cyc(1); addr_err = 1'b0; end
                    cyc(2);
                    expb = en & run & ~te & (f == 0) & (md ? rq : 1'b1);
                    if (f == 1)      tag = "R6 sweep";
                    else if (f == 2) tag = "R7 sweep";
                    else if (te)     tag = "R5 sweep";
                    else if (md)     tag = "R4 sweep";
                    else             tag = "R3 sweep";
                    chk(tag, 32'(permit), 32'(NCH'(expb) << ch));
                    rd('0, d);
                    chk(tag, 32'(d), 32'(run) | (32'(f == 1) << 1) | (32'(f == 2) << 2));
                end
            end
        end

        // R6: flag visible at once, permits drop one cycle later
        clear_all();
        wr(1, 16'h1); wr(2, 16'h1); wr(0, 16'h1);
        cyc(2);
        chk("R3 two channels", 32'(permit), 32'h3);
        nmi_in = 1'b1;
        cyc(1);
        nmi_in = 1'b0;
        rd('0, d);
        chk("R6 flag set", 32'(d[1]), 32'h1);
        chk("R6 permit still high", 32'(permit), 32'h3);
        cyc(1);
        chk("R6 permit dropped", 32'(permit), 32'h0);

        // R9: same-cycle set and clear, set wins
        bus_addr = '0; bus_wdata = 16'h0001; bus_wr = 1'b1; nmi_in = 1'b1;
        cyc(1);
        bus_wr = 1'b0; nmi_in = 1'b0;
        rd('0, d);
        chk("R9 set wins", 32'(d[1]), 32'h1);

        // R8: write 1 keeps, write 0 clears, write 1 does not set
        wr('0, 16'h0003);
        rd('0, d);
        chk("R8 write one keeps", 32'(d[1]), 32'h1);
        wr('0, 16'h0001);
        rd('0, d);
        chk("R8 write zero clears", 32'(d), 32'h0001);
        wr('0, 16'h0007);
        rd('0, d);
        chk("R8 write one no set", 32'(d), 32'h0001);
        cyc(1);
        chk("R8 permits resume", 32'(permit), 32'h3);

        // R10: reserved bits and priority field
        wr('0, 16'hFFFF);
        rd('0, d);
        chk("R10 all ones", 32'(d), 32'h0301);
        wr('0, 16'h0200);
        rd('0, d);
        chk("R10 priority", 32'(d), 32'h0200);

        // R11: master run cleared
        wr('0, 16'h0001);
        cyc(2);
        chk("R11 running", 32'(permit), 32'h3);
        wr('0, 16'h0000);
        cyc(1);
        chk("R11 stopped", 32'(permit), 32'h0);

        // R12: channel enable cleared
        wr('0, 16'h0001);
        cyc(2);
        wr(1, 16'h0000);
        cyc(1);
        chk("R12 channel stopped", 32'(permit), 32'h2);

        // R4: external request timing
        mode_ext = 4'b0010; req = '0;
        cyc(2);
        chk("R4 no request", 32'(permit), 32'h0);
        req = 4'b0010;
        cyc(1);
        chk("R4 request seen", 32'(permit), 32'h2);
        req = '0;
        cyc(1);
        chk("R4 request gone", 32'(permit), 32'h0);
        mode_ext = '0;

        // R13: channel register width and unmapped addresses
        wr(3, 16'hFFFF);
        rd(3, d);
        chk("R13 channel bits", 32'(d), 32'h0001);
        wr(AW'(NCH + 1), 16'hFFFF);
        wr(4'hF, 16'h0000);
        rd(AW'(NCH + 1), d);
        chk("R13 unmapped read", 32'(d), 32'h0);
        rd(3, d);
        chk("R13 channel untouched", 32'(d), 32'h0001);
        rd('0, d);
        chk("R13 runctl untouched", 32'(d), 32'h0001);
        cyc(1);
        chk("R13 permits untouched", 32'(permit), 32'h6);

        // R2: standby clears everything, flags included
        wr('0, 16'h0301);
        addr_err = 1'b1; cyc(1); addr_err = 1'b0;
        clear_all();
        for (int a = 0; a <= NCH; a++) begin
            rd(AW'(a), d);
            chk("R2 read", 32'(d), 32'h0);
        end
        chk("R2 permit", 32'(permit), 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule